// File: doc/BRIEF.md
# Dual-Ring Host/Responder Mailbox

This block is a register-mapped mailbox that sits between a host processor and a responder engine. The host places command words into a command ring and publishes how far it has written by updating a producer offset. The responder drains those words one at a time. Replies travel the other way through a response ring that the responder fills and the host consumes. In each ring one offset belongs to software and the other to hardware. A ring is empty when its two offsets match. It is full when advancing the producer by one would make them match, so one slot always stays unused.

Alongside the rings there is a doorbell in each direction and an urgent-request flag. The responder acknowledges an urgent request by flipping a status bit, not by writing response words. An interrupt-enable register selects which host-side conditions drive the host interrupt line. The host reaches all of this through a word-addressed register port with a valid/ready handshake and registered read data. The responder has a narrow port to pop commands, push responses, ring the host doorbell and acknowledge urgent requests.

Register map (word addresses):
- 0: command producer offset (host read/write)
- 1: command consumer offset (read only)
- 2: response producer offset (read only)
- 3: response consumer offset (host read/write)
- 4: doorbell to the responder
- 5: doorbell to the host
- 6: urgent request
- 7: status
- 8: interrupt enable
- 16 + i: command buffer word i (write only)
- 32 + i: response buffer word i (read only)

Top module: `mbox_regs`

## Requirements
- R1: After reset every offset, both doorbells, the urgent flag, the urgent-ack bit and the interrupt enables read 0. The status word (address 7) reads 0x00070704 with the default depth of 8.
- R2: A host write to address 0 stores the low log2(depth) bits of the data as the command producer offset. Bit 1 of status is set exactly when (in + 1) mod depth equals out. `cmd_valid` is high exactly when in differs from out.
- R3: Status bits [15:8] hold the free command space (depth − in + out − 1) mod depth. Status bits [23:16] hold the free response space (depth − in + out − 1) mod depth, computed from the response offsets.
- R4: `cmd_word` shows command buffer word [out]. A pop while `cmd_valid` is high advances out by one, modulo depth. A pop while the ring is empty changes nothing.
- R5: An accepted push writes response buffer word [in] and advances in modulo depth. `rsp_push_ready` is low when (in + 1) mod depth equals out. A push offered while ready is low writes nothing and leaves in unchanged.
- R6: Status bit 2 is set exactly when the response offsets are equal. A host write to address 3 sets the response consumer offset. The host reads response word i at address 32 + i.
- R7: Writing address 4 with bit 0 = 1 raises `resp_doorbell`. Writing it with bit 0 = 0 has no effect. `resp_db_clr` clears it, but a host set in the same cycle wins.
- R8: `host_db_ring` sets bit 0 of address 5. A host write of bit 0 = 0 to address 5 clears it, and a write of 1 has no effect. A ring in the same cycle as a clear wins.
- R9: Bit 0 written to address 6 drives `urgent_req`. Urgent traffic never moves either response offset.
- R10: Each cycle with `urg_ack` high inverts status bit 0. With `urg_ack` low the bit holds.
- R11: Address 8 holds two enables. Bit 0 enables the host doorbell and bit 1 enables response-ring non-empty. `host_irq` is the OR of the enabled sources, so writing all ones enables both.
- R12: Host writes to read-only registers, to the response buffer, and to command buffer addresses at or above 16 + depth leave all state unchanged. Reads of unmapped addresses return 0.
- R13: `host_ready` is always high. Read data and `host_rvalid` appear one cycle after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host register request valid |
| host_ready | output | 1 | Host request accepted (always 1) |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | Word address |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Registered read data |
| host_rvalid | output | 1 | Read data valid |
| host_irq | output | 1 | Host interrupt |
| cmd_valid | output | 1 | Command ring not empty |
| cmd_word | output | DW | Command word at the consumer offset |
| cmd_pop | input | 1 | Consume one command word |
| rsp_push_valid | input | 1 | Response word offered |
| rsp_push_data | input | DW | Response word |
| rsp_push_ready | output | 1 | Response ring has room |
| resp_doorbell | output | 1 | Doorbell pending toward responder |
| resp_db_clr | input | 1 | Responder clears its doorbell |
| host_db_ring | input | 1 | Responder rings host doorbell |
| urgent_req | output | 1 | Urgent request flag |
| urg_ack | input | 1 | Urgent acknowledge pulse |

## Verification
The bound checker checks on every cycle that the urgent-ack bit flips on each acknowledge and holds otherwise, and that a refused push or an empty pop leaves the hardware-owned offset alone. It also checks that a responder ring always leaves the host doorbell set, and that each read is answered exactly one cycle later. The bench covers what only scenarios can show. It sweeps every pair of command offsets and compares full, valid and free space against arithmetic. It checks word order through wraparound of both rings, that an out-of-range buffer write does not alias into slot 0, and the doorbell collision priorities. It also checks interrupt gating and that urgent traffic leaves the response ring untouched.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned NIRQ   = 2;

  localparam logic [ADDR_W-1:0] A_CMD_IN  = 6'd0;
  localparam logic [ADDR_W-1:0] A_CMD_OUT = 6'd1;
  localparam logic [ADDR_W-1:0] A_RSP_IN  = 6'd2;
  localparam logic [ADDR_W-1:0] A_RSP_OUT = 6'd3;
  localparam logic [ADDR_W-1:0] A_DB_RSP  = 6'd4;
  localparam logic [ADDR_W-1:0] A_DB_HOST = 6'd5;
  localparam logic [ADDR_W-1:0] A_URGENT  = 6'd6;
  localparam logic [ADDR_W-1:0] A_STATUS  = 6'd7;
  localparam logic [ADDR_W-1:0] A_IRQ_EN  = 6'd8;
  localparam logic [ADDR_W-1:0] A_CMD_BUF = 6'd16;
  localparam logic [ADDR_W-1:0] A_RSP_BUF = 6'd32;

  // interrupt source bit positions
  localparam int unsigned IRQ_HOST_DB  = 0;
  localparam int unsigned IRQ_RSP_NEMP = 1;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/mbox_ring.sv
module mbox_ring #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prod_set,
  input  logic [PW-1:0] prod_val,
  input  logic          prod_inc,
  input  logic          cons_set,
  input  logic [PW-1:0] cons_val,
  input  logic          cons_inc,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [PW-1:0] prod_ptr,
  output logic [PW-1:0] cons_ptr,
  output logic          full,
  output logic          empty,
  output logic [PW-1:0] free_cnt
);
  logic [PW-1:0] prod_q, prod_d, cons_q, cons_d;
  logic [DW-1:0] mem [DEPTH];

  always_comb begin
    prod_d = prod_q;
    if (prod_set)      prod_d = prod_val;
    else if (prod_inc) prod_d = prod_q + 1'b1;
    cons_d = cons_q;
    if (cons_set)      cons_d = cons_val;
    else if (cons_inc) cons_d = cons_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      cons_q <= '0;
    end else begin
      prod_q <= prod_d;
      cons_q <= cons_d;
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_word
    logic we_k;
    assign we_k = wr_en && (wr_idx == PW'(k));
    always_ff @(posedge clk) begin
      if (we_k) mem[k] <= wr_data;
    end
  end

  assign rd_data  = mem[rd_idx];
  assign prod_ptr = prod_q;
  assign cons_ptr = cons_q;
  assign empty    = (prod_q == cons_q);
  assign full     = ((prod_q + 1'b1) == cons_q);
  assign free_cnt = cons_q - prod_q - 1'b1;
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rdb_set,
  input  logic            rdb_clr,
  input  logic            hdb_ring,
  input  logic            hdb_clr,
  input  logic            urg_wr,
  input  logic            urg_val,
  input  logic            urg_ack,
  input  logic            ien_wr,
  input  logic [NIRQ-1:0] ien_val,
  input  logic [NIRQ-1:0] irq_src,
  output logic            rdb_q,
  output logic            hdb_q,
  output logic            urg_q,
  output logic            uack_q,
  output logic [NIRQ-1:0] ien_q,
  output logic            irq
);
  logic rdb_d, hdb_d, urg_d, uack_d;
  logic [NIRQ-1:0] ien_d;

  always_comb begin
    rdb_d  = rdb_set ? 1'b1 : (rdb_clr ? 1'b0 : rdb_q);
    hdb_d  = hdb_ring ? 1'b1 : (hdb_clr ? 1'b0 : hdb_q);
    urg_d  = urg_wr ? urg_val : urg_q;
    uack_d = uack_q ^ urg_ack;
    ien_d  = ien_wr ? ien_val : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdb_q  <= 1'b0;
      hdb_q  <= 1'b0;
      urg_q  <= 1'b0;
      uack_q <= 1'b0;
      ien_q  <= '0;
    end else begin
      rdb_q  <= rdb_d;
      hdb_q  <= hdb_d;
      urg_q  <= urg_d;
      uack_q <= uack_d;
      ien_q  <= ien_d;
    end
  end

  assign irq = |(ien_q & irq_src);
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned CMD_DEPTH = 8,
  parameter int unsigned RSP_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_rvalid,
  output logic              host_irq,
  output logic              cmd_valid,
  output logic [DW-1:0]     cmd_word,
  input  logic              cmd_pop,
  input  logic              rsp_push_valid,
  input  logic [DW-1:0]     rsp_push_data,
  output logic              rsp_push_ready,
  output logic              resp_doorbell,
  input  logic              resp_db_clr,
  input  logic              host_db_ring,
  output logic              urgent_req,
  input  logic              urg_ack
);
  localparam int unsigned CPW = $clog2(CMD_DEPTH);
  localparam int unsigned RPW = $clog2(RSP_DEPTH);

  logic rst_s_n;
  logic wr_acc, rd_acc, in_cmd_win, in_rsp_win;
  logic [CPW-1:0] cmd_in_ptr, cmd_out_ptr, cmd_free, cmd_idx;
  logic [RPW-1:0] rsp_in_ptr, rsp_out_ptr, rsp_free, rsp_idx;
  logic cmd_full, cmd_empty, rsp_full, rsp_empty, push_acc;
  logic [DW-1:0] rsp_rd_word, status_w, rdata_d, rdata_q;
  logic rvalid_q;
  logic host_db, uack;
  logic [NIRQ-1:0] irq_en, irq_src;

  mbox_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  assign host_ready = 1'b1;
  assign wr_acc     = host_valid && host_we;
  assign rd_acc     = host_valid && !host_we;
  assign in_cmd_win = (host_addr >= A_CMD_BUF) &&
                      (int'(host_addr) < int'(A_CMD_BUF) + int'(CMD_DEPTH));
  assign in_rsp_win = (host_addr >= A_RSP_BUF) &&
                      (int'(host_addr) < int'(A_RSP_BUF) + int'(RSP_DEPTH));
  assign cmd_idx    = CPW'(host_addr - A_CMD_BUF);
  assign rsp_idx    = RPW'(host_addr - A_RSP_BUF);
  assign push_acc   = rsp_push_valid && !rsp_full;

  mbox_ring #(.DEPTH(CMD_DEPTH), .DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_s_n),
    .prod_set(wr_acc && host_addr == A_CMD_IN), .prod_val(host_wdata[CPW-1:0]),
    .prod_inc(1'b0),
    .cons_set(1'b0), .cons_val('0), .cons_inc(cmd_pop && !cmd_empty),
    .wr_en(wr_acc && in_cmd_win), .wr_idx(cmd_idx), .wr_data(host_wdata),
    .rd_idx(cmd_out_ptr), .rd_data(cmd_word),
    .prod_ptr(cmd_in_ptr), .cons_ptr(cmd_out_ptr),
    .full(cmd_full), .empty(cmd_empty), .free_cnt(cmd_free)
  );

  mbox_ring #(.DEPTH(RSP_DEPTH), .DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_s_n),
    .prod_set(1'b0), .prod_val('0), .prod_inc(push_acc),
    .cons_set(wr_acc && host_addr == A_RSP_OUT), .cons_val(host_wdata[RPW-1:0]),
    .cons_inc(1'b0),
    .wr_en(push_acc), .wr_idx(rsp_in_ptr), .wr_data(rsp_push_data),
    .rd_idx(rsp_idx), .rd_data(rsp_rd_word),
    .prod_ptr(rsp_in_ptr), .cons_ptr(rsp_out_ptr),
    .full(rsp_full), .empty(rsp_empty), .free_cnt(rsp_free)
  );

  assign irq_src[IRQ_HOST_DB]  = host_db;
  assign irq_src[IRQ_RSP_NEMP] = !rsp_empty;

  mbox_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s_n),
    .rdb_set(wr_acc && host_addr == A_DB_RSP && host_wdata[0]),
    .rdb_clr(resp_db_clr),
    .hdb_ring(host_db_ring),
    .hdb_clr(wr_acc && host_addr == A_DB_HOST && !host_wdata[0]),
    .urg_wr(wr_acc && host_addr == A_URGENT), .urg_val(host_wdata[0]),
    .urg_ack(urg_ack),
    .ien_wr(wr_acc && host_addr == A_IRQ_EN), .ien_val(host_wdata[NIRQ-1:0]),
    .irq_src(irq_src),
    .rdb_q(resp_doorbell), .hdb_q(host_db), .urg_q(urgent_req),
    .uack_q(uack), .ien_q(irq_en), .irq(host_irq)
  );

  assign cmd_valid      = !cmd_empty;
  assign rsp_push_ready = !rsp_full;

  always_comb begin
    status_w          = '0;
    status_w[0]       = uack;
    status_w[1]       = cmd_full;
    status_w[2]       = rsp_empty;
    status_w[8 +: CPW]  = cmd_free;
    status_w[16 +: RPW] = rsp_free;
  end

  always_comb begin
    rdata_d = '0;
    unique case (host_addr)
      A_CMD_IN:  rdata_d = DW'(cmd_in_ptr);
      A_CMD_OUT: rdata_d = DW'(cmd_out_ptr);
      A_RSP_IN:  rdata_d = DW'(rsp_in_ptr);
      A_RSP_OUT: rdata_d = DW'(rsp_out_ptr);
      A_DB_RSP:  rdata_d = DW'(resp_doorbell);
      A_DB_HOST: rdata_d = DW'(host_db);
      A_URGENT:  rdata_d = DW'(urgent_req);
      A_STATUS:  rdata_d = status_w;
      A_IRQ_EN:  rdata_d = DW'(irq_en);
      default:   rdata_d = in_rsp_win ? rsp_rd_word : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) rdata_q <= rdata_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;
endmodule

// File: rtl/mbox_regs_chk.sv
module mbox_regs_chk #(
  parameter int unsigned CPW = 3,
  parameter int unsigned RPW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           urg_ack,
  input logic           uack,
  input logic           rsp_push_valid,
  input logic           rsp_push_ready,
  input logic [RPW-1:0] rsp_in_ptr,
  input logic           cmd_pop,
  input logic           cmd_valid,
  input logic [CPW-1:0] cmd_out_ptr,
  input logic           host_db_ring,
  input logic           host_db,
  input logic           host_valid,
  input logic           host_we,
  input logic           host_rvalid
);
  a_r10_ack_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    urg_ack |=> (uack != $past(uack)));

  a_r10_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !urg_ack |=> $stable(uack));

  a_r5_refused_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_push_valid && rsp_push_ready) |=> $stable(rsp_in_ptr));

  a_r4_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pop && !cmd_valid) |=> $stable(cmd_out_ptr));

  a_r4_pop_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pop && cmd_valid) |=> (cmd_out_ptr == $past(cmd_out_ptr) + 1'b1));

  a_r8_ring_sets: assert property (@(posedge clk) disable iff (!rst_n)
    host_db_ring |=> host_db);

  a_r13_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_we) |=> host_rvalid);
endmodule

bind mbox_regs mbox_regs_chk #(.CPW(CPW), .RPW(RPW)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .urg_ack(urg_ack), .uack(uack),
  .rsp_push_valid(rsp_push_valid), .rsp_push_ready(rsp_push_ready),
  .rsp_in_ptr(rsp_in_ptr), .cmd_pop(cmd_pop), .cmd_valid(cmd_valid),
  .cmd_out_ptr(cmd_out_ptr), .host_db_ring(host_db_ring), .host_db(host_db),
  .host_valid(host_valid), .host_we(host_we), .host_rvalid(host_rvalid)
);

// File: tb/tb_mbox_regs.sv
`timescale 1ns/1ps
module tb_mbox_regs;
  localparam int D = 8;
  logic clk = 1'b0;
  logic rst_n;
  logic host_valid, host_ready, host_we, host_rvalid, host_irq;
  logic [5:0] host_addr;
  logic [31:0] host_wdata, host_rdata, cmd_word, rsp_push_data;
  logic cmd_valid, cmd_pop, rsp_push_valid, rsp_push_ready;
  logic resp_doorbell, resp_db_clr, host_db_ring, urgent_req, urg_ack;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbox_regs dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    host_valid = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 0; host_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    host_valid = 1; host_we = 0; host_addr = a;
    @(negedge clk);
    d = host_rdata;
    host_valid = 0;
  endtask

  task automatic pop();
    @(negedge clk); cmd_pop = 1;
    @(negedge clk); cmd_pop = 0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); rsp_push_valid = 1; rsp_push_data = d;
    @(negedge clk); rsp_push_valid = 0;
  endtask

  task automatic ack();
    @(negedge clk); urg_ack = 1;
    @(negedge clk); urg_ack = 0;
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_up();
    end
  end

  initial begin
    logic [31:0] v;
    host_valid = 0; host_we = 0; host_addr = '0; host_wdata = '0;
    cmd_pop = 0; rsp_push_valid = 0; rsp_push_data = '0;
    resp_db_clr = 0; host_db_ring = 0; urg_ack = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(6'(a), v);
      chk($sformatf("R1 reg %0d", a), v, (a == 7) ? 32'h0007_0704 : 32'h0);
    end
    chk("R1 cmd_valid", {31'b0, cmd_valid}, 0);
    chk("R1 urgent_req", {31'b0, urgent_req}, 0);
    chk("R13 host_ready", {31'b0, host_ready}, 1);

    // R2/R3 sweep of every in/out pair on the command ring
    for (int o = 0; o < D; o++) begin
      for (int i = 0; i < D; i++) begin
        wr(6'd0, 32'(i));
        rd(6'd7, v);
        chk($sformatf("R2 full in=%0d out=%0d", i, o), {31'b0, v[1]}, {31'b0, ((i + 1) % D) == o});
        chk($sformatf("R3 free in=%0d out=%0d", i, o), {24'b0, v[15:8]}, 32'((D - i + o - 1) % D));
        chk($sformatf("R2 valid in=%0d out=%0d", i, o), {31'b0, cmd_valid}, {31'b0, i != o});
      end
      wr(6'd0, 32'((o + 1) % D));
      pop();
    end

    // R4 pop on empty ring
    wr(6'd0, 32'd0);
    pop();
    rd(6'd1, v);
    chk("R4 empty pop keeps out", v, 0);
    // R12 read-only register write
    wr(6'd1, 32'd5);
    rd(6'd1, v);
    chk("R12 cmd out read-only", v, 0);
    // R2 offset truncation
    wr(6'd0, 32'hFFFF_FFF3);
    rd(6'd0, v);
    chk("R2 offset modulo", v, 3);
    wr(6'd0, 32'd0);

    // R4/R12 command words in order, out-of-range write does not alias
    for (int k = 0; k < D; k++) wr(6'(16 + k), 32'hC0DE_0000 + 32'(k));
    wr(6'(16 + D), 32'h0000_0BAD);
    rd(6'(16 + D), v);
    chk("R12 unmapped read zero", v, 0);
    wr(6'd0, 32'(D - 1));
    for (int k = 0; k < D - 1; k++) begin
      @(negedge clk);
      chk($sformatf("R4 cmd word %0d", k), cmd_word, 32'hC0DE_0000 + 32'(k));
      pop();
    end
    wr(6'(16 + D - 1), 32'h1111_0007);
    wr(6'd16, 32'h1111_0000);
    wr(6'd0, 32'd1);
    chk("R4 wrap word 7", cmd_word, 32'h1111_0007);
    pop();
    chk("R4 wrap word 0", cmd_word, 32'h1111_0000);
    pop();
    chk("R2 drained", {31'b0, cmd_valid}, 0);

    // R5/R6 response ring fill
    for (int k = 0; k < D - 1; k++) begin
      chk($sformatf("R5 ready before push %0d", k), {31'b0, rsp_push_ready}, 1);
      push(32'hA500 + 32'(k));
    end
    chk("R5 ready low when full", {31'b0, rsp_push_ready}, 0);
    push(32'hDEAD);
    rd(6'd2, v);
    chk("R5 refused push keeps in", v, D - 1);
    rd(6'd7, v);
    chk("R6 not empty", {31'b0, v[2]}, 0);
    chk("R3 rsp free zero", {24'b0, v[23:16]}, 0);
    wr(6'd32, 32'h5555);
    for (int k = 0; k < D - 1; k++) begin
      rd(6'(32 + k), v);
      chk($sformatf("R6 rsp word %0d", k), v, 32'hA500 + 32'(k));
    end
    // R11 interrupt gating
    wr(6'd8, 32'hFFFF_FFFF);
    rd(6'd8, v);
    chk("R11 enable all", v, 3);
    chk("R11 irq rsp nonempty", {31'b0, host_irq}, 1);
    wr(6'd3, 32'(D - 1));
    rd(6'd7, v);
    chk("R6 empty after consume", {31'b0, v[2]}, 1);
    chk("R3 rsp free", {24'b0, v[23:16]}, D - 1);
    chk("R11 irq clears", {31'b0, host_irq}, 0);
    for (int k = 0; k < 3; k++) push(32'hB700 + 32'(k));
    rd(6'd2, v);
    chk("R5 rsp in wrapped", v, 2);
    for (int k = 0; k < 3; k++) begin
      rd(6'(32 + ((D - 1 + k) % D)), v);
      chk($sformatf("R5 wrap word %0d", k), v, 32'hB700 + 32'(k));
    end
    wr(6'd3, 32'd2);

    // R7 responder doorbell
    wr(6'd4, 32'd0);
    chk("R7 write 0 no effect", {31'b0, resp_doorbell}, 0);
    wr(6'd4, 32'd1);
    chk("R7 set", {31'b0, resp_doorbell}, 1);
    @(negedge clk); resp_db_clr = 1;
    @(negedge clk); resp_db_clr = 0;
    chk("R7 cleared", {31'b0, resp_doorbell}, 0);
    @(negedge clk);
    host_valid = 1; host_we = 1; host_addr = 6'd4; host_wdata = 1; resp_db_clr = 1;
    @(negedge clk);
    host_valid = 0; host_we = 0; resp_db_clr = 0;
    chk("R7 set wins", {31'b0, resp_doorbell}, 1);

    // R8/R11 host doorbell
    wr(6'd8, 32'd1);
    @(negedge clk); host_db_ring = 1;
    @(negedge clk); host_db_ring = 0;
    rd(6'd5, v);
    chk("R8 rung", v, 1);
    chk("R11 irq doorbell", {31'b0, host_irq}, 1);
    wr(6'd5, 32'd1);
    rd(6'd5, v);
    chk("R8 write 1 no effect", v, 1);
    wr(6'd5, 32'd0);
    rd(6'd5, v);
    chk("R8 cleared", v, 0);
    chk("R11 irq off", {31'b0, host_irq}, 0);
    @(negedge clk);
    host_valid = 1; host_we = 1; host_addr = 6'd5; host_wdata = 0; host_db_ring = 1;
    @(negedge clk);
    host_valid = 0; host_we = 0; host_db_ring = 0;
    rd(6'd5, v);
    chk("R8 ring wins", v, 1);

    // R9/R10 urgent request and toggle acknowledge
    wr(6'd6, 32'd1);
    chk("R9 urgent raised", {31'b0, urgent_req}, 1);
    for (int n = 1; n <= 5; n++) begin
      ack();
      rd(6'd7, v);
      chk($sformatf("R10 ack %0d", n), {31'b0, v[0]}, 32'(n % 2));
    end
    @(negedge clk); urg_ack = 1;
    @(negedge clk); @(negedge clk); urg_ack = 0;
    rd(6'd7, v);
    chk("R10 two-cycle ack", {31'b0, v[0]}, 1);
    rd(6'd2, v);
    chk("R9 no response words", v, 2);
    wr(6'd6, 32'd0);
    chk("R9 urgent dropped", {31'b0, urgent_req}, 0);

    // R13 read timing
    @(negedge clk);
    host_valid = 1; host_we = 0; host_addr = 6'd0;
    chk("R13 rvalid not same cycle", {31'b0, host_rvalid}, 0);
    @(negedge clk);
    host_valid = 0;
    chk("R13 rvalid next cycle", {31'b0, host_rvalid}, 1);
    @(negedge clk);
    chk("R13 rvalid drops", {31'b0, host_rvalid}, 0);

    done = 1;
    finish_up();
  end
endmodule